// File: doc/BRIEF.md
# Pin Interrupt Condition Detector

This block watches a bank of general-purpose input pins and raises a single summary interrupt when any pin meets the condition programmed for it. Each pin input first passes through a synchroniser. Each pin then has its own configuration register and a sticky status bit. The configuration selects one of three kinds of condition: a level condition (high or low), a single edge (rising or falling), or both edges. It also holds a gate that lets the status bit capture at all, an interrupt enable, and a 3-bit routing field for the destination processor.

The detection field comes in two build variants. In the wide variant, a 2-bit code selects level, rising, falling or both edges directly. In the narrow variant, a single bit selects edge or level, and the polarity bit picks the edge. In that case software catches alternate edges by flipping the polarity after each event. Software clears status bits through a vector write, and a parameter chooses whether a 1 or a 0 in that vector performs the clear. The summary output is the OR, over all pins, of status bits whose interrupt enable is set.

Top module: `gpio_irq_detector`

## Requirements
- R1: After reset, every status bit, the summary interrupt and every routing flag are 0.
- R2: Wide variant: a pin with detection code 1 (rising) sets its status bit on a 0-to-1 input change and not on a 1-to-0 change. Configuration byte layout is [7] irq enable, [6] capture gate, [5] polarity, [4:3] detection code, [2:0] target.
- R3: Wide variant: detection code 2 (falling) sets status only on a 1-to-0 input change.
- R4: Wide variant: detection code 3 sets status on both input edges.
- R5: Detection code 0 is level mode. Polarity 1 matches a high input and polarity 0 matches a low input. In this mode the status bit follows the qualified level and cannot be cleared while the level holds.
- R6: Narrow variant: bit 3 set selects edge mode, and bit 4 is ignored. Polarity 1 catches rising edges only and polarity 0 catches falling edges only, so the opposite edge is caught after software flips the polarity.
- R7: With the capture gate (bit 6) at 0, no input activity sets a status bit.
- R8: In edge modes a status bit stays set until cleared. With clear-on-one, a 1 in the clear vector clears it and a 0 does not. With clear-on-zero, the opposite holds.
- R9: A clear applied in the same cycle as a newly detected edge leaves the status bit set.
- R10: The summary interrupt is high exactly when some pin has both its status bit and its irq enable set.
- R11: The routing flag of a pin is high when its target field equals 4.
- R12: A configuration write changes only the pin that the select input addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Pin addressed by the configuration write |
| cfg_wdata | input | 8 | Configuration byte (layout in R2) |
| clr_we | input | 1 | Status clear strobe |
| clr_data | input | NUM_PINS | Clear vector, one bit per pin |
| status_o | output | NUM_PINS | Status bits |
| irq_o | output | 1 | Summary interrupt |
| app_route_o | output | NUM_PINS | Pin targets the application processor |

## Verification
A pin change passes two synchroniser flops, and the status register then captures the detected event. As a result, status and the summary interrupt move three rising edges after the bench drives the pin. A configuration write or a clear takes effect one edge after its strobe. The driver tasks push each expected value with the cycle number at which it is due. The monitor compares on the falling edge of exactly that cycle. For the same-cycle clear case, the clear strobe is timed to land on the cycle in which the synchronised edge is seen, which is two edges after the pin change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int CFG_W     = 8;
    localparam int TGT_W     = 3;
    localparam logic [TGT_W-1:0] TGT_APP = 3'd4;

    // Per-pin configuration byte, MSB first.
    typedef struct packed {
        logic             irq_en;
        logic             cap_en;
        logic             pol;
        logic [1:0]       det;
        logic [TGT_W-1:0] tgt;
    } pin_cfg_t;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        if (STAGES > 1)
            sh_d = {sh_q[STAGES-2:0], d};
        else
            sh_d = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
#(
    parameter int DET_W      = 2,
    parameter bit CLR_ON_ONE = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     s_in,
    input  logic     cfg_we,
    input  pin_cfg_t cfg_wdata,
    input  logic     clr_we,
    input  logic     clr_bit,
    output logic     status_o,
    output logic     irq_o,
    output logic     app_o
);
    typedef struct packed {
        pin_cfg_t cfg;
        logic     prev;
        logic     status;
    } pin_state_t;

    pin_state_t state_d, state_q;

    logic is_level, watch_rise, watch_fall;
    logic rise, fall, lvl_hit, edge_hit, ev, clr;

    // Detection-code decode, chosen by variant
    generate
        if (DET_W == 2) begin : g_det_wide
            always_comb begin
                is_level   = (state_q.cfg.det == 2'd0);
                watch_rise = state_q.cfg.det[0];
                watch_fall = state_q.cfg.det[1];
            end
        end else begin : g_det_narrow
            always_comb begin
                is_level   = ~state_q.cfg.det[0];
                watch_rise = state_q.cfg.det[0] &  state_q.cfg.pol;
                watch_fall = state_q.cfg.det[0] & ~state_q.cfg.pol;
            end
        end
    endgenerate

    always_comb begin
        state_d  = state_q;
        rise     = s_in & ~state_q.prev;
        fall     = ~s_in & state_q.prev;
        lvl_hit  = state_q.cfg.pol ? s_in : ~s_in;
        edge_hit = (watch_rise & rise) | (watch_fall & fall);
        ev       = state_q.cfg.cap_en & (is_level ? lvl_hit : edge_hit);
        clr      = clr_we & (CLR_ON_ONE ? clr_bit : ~clr_bit);

        state_d.prev = s_in;
        if (cfg_we)
            state_d.cfg = cfg_wdata;
        if (is_level)
            state_d.status = ev;
        else
            state_d.status = ev | (state_q.status & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign status_o = state_q.status;
    assign irq_o    = state_q.status & state_q.cfg.irq_en;
    assign app_o    = (state_q.cfg.tgt == TGT_APP);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_level && state_q.status && !clr) |=> state_q.status)
        else $error("edge status dropped without a clear");

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_level && clr && !ev) |=> !state_q.status)
        else $error("clear did not drop edge status");

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_level && ev) |=> state_q.status)
        else $error("detected edge lost");

    p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.cfg.cap_en && !state_q.status) |=> !state_q.status)
        else $error("status set with capture gate off");
endmodule

// File: rtl/gpio_irq_detector.sv
module gpio_irq_detector
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int DET_W       = 2,
    parameter bit CLR_ON_ONE  = 1'b1,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                clr_we,
    input  logic [NUM_PINS-1:0] clr_data,
    output logic [NUM_PINS-1:0] status_o,
    output logic                irq_o,
    output logic [NUM_PINS-1:0] app_route_o
);
    logic [NUM_PINS-1:0] pin_s;
    logic [NUM_PINS-1:0] pin_irq;

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            logic sel_hit;
            assign sel_hit = cfg_we && (cfg_sel == SEL_W'(i));

            gpio_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (pin_in[i]),
                .q     (pin_s[i])
            );

            gpio_irq_pin #(.DET_W(DET_W), .CLR_ON_ONE(CLR_ON_ONE)) u_det (
                .clk       (clk),
                .rst_n     (rst_n),
                .s_in      (pin_s[i]),
                .cfg_we    (sel_hit),
                .cfg_wdata (pin_cfg_t'(cfg_wdata)),
                .clr_we    (clr_we),
                .clr_bit   (clr_data[i]),
                .status_o  (status_o[i]),
                .irq_o     (pin_irq[i]),
                .app_o     (app_route_o[i])
            );
        end
    endgenerate

    assign irq_o = |pin_irq;

    p_irq_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(status_o) == 0) |-> !irq_o)
        else $error("summary interrupt with no status");
endmodule

// File: tb/sim_gpio_irq_detector.sv
module sim_gpio_irq_detector;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // DUT 0: wide detection, clear-on-one, 8 pins
    logic [7:0] p0 = '0, clrd0 = '0, wd0 = '0;
    logic [2:0] sel0 = '0;
    logic       cwe0 = 1'b0, clw0 = 1'b0;
    logic [7:0] st0, rt0;
    logic       irq0;

    // DUT 1: narrow detection, clear-on-zero, 4 pins
    logic [3:0] p1 = '0, clrd1 = '1, st1, rt1;
    logic [7:0] wd1 = '0;
    logic [1:0] sel1 = '0;
    logic       cwe1 = 1'b0, clw1 = 1'b0, irq1;

    gpio_irq_detector u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(p0), .cfg_we(cwe0), .cfg_sel(sel0),
        .cfg_wdata(wd0), .clr_we(clw0), .clr_data(clrd0),
        .status_o(st0), .irq_o(irq0), .app_route_o(rt0));

    gpio_irq_detector #(.NUM_PINS(4), .DET_W(1), .CLR_ON_ONE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .pin_in(p1), .cfg_we(cwe1), .cfg_sel(sel1),
        .cfg_wdata(wd1), .clr_we(clw1), .clr_data(clrd1),
        .status_o(st1), .irq_o(irq1), .app_route_o(rt1));

    typedef struct {
        int         dut;
        int         due;
        logic [7:0] st;
        logic       irq;
        logic [7:0] rt;
        string      tag;
    } exp_t;

    exp_t exq[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares each expected item on the falling edge it is due
    always @(negedge clk) begin
        while (exq.size() > 0 && exq[0].due == cyc) begin
            exp_t e;
            logic [7:0] a_st, a_rt;
            logic       a_irq;
            e = exq.pop_front();
            if (e.dut == 0) begin a_st = st0; a_rt = rt0; a_irq = irq0; end
            else begin a_st = {4'b0, st1}; a_rt = {4'b0, rt1}; a_irq = irq1; end
            n_chk++;
            if (a_st !== e.st || a_irq !== e.irq || a_rt !== e.rt) begin
                n_fail++;
                $display("FAIL %s dut%0d: status=%h irq=%b route=%h expected status=%h irq=%b route=%h",
                         e.tag, e.dut, a_st, a_irq, a_rt, e.st, e.irq, e.rt);
            end
        end
    end

    task automatic expect_at(int d, int dly, logic [7:0] s, logic i, logic [7:0] r, string t);
        exp_t e;
        e.dut = d; e.due = cyc + dly; e.st = s; e.irq = i; e.rt = r; e.tag = t;
        exq.push_back(e);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg0(int pin, logic [7:0] v);
        sel0 = 3'(pin); wd0 = v; cwe0 = 1'b1;
        @(negedge clk);
        cwe0 = 1'b0;
    endtask

    task automatic cfg1(int pin, logic [7:0] v);
        sel1 = 2'(pin); wd1 = v; cwe1 = 1'b1;
        @(negedge clk);
        cwe1 = 1'b0;
    endtask

    task automatic clr0(logic [7:0] v);
        clrd0 = v; clw0 = 1'b1;
        @(negedge clk);
        clw0 = 1'b0; clrd0 = '0;
    endtask

    task automatic clr1(logic [3:0] v);
        clrd1 = v; clw1 = 1'b1;
        @(negedge clk);
        clw1 = 1'b0; clrd1 = '1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_at(0, 0, 8'h00, 1'b0, 8'h00, "R1 reset");
        expect_at(1, 0, 8'h00, 1'b0, 8'h00, "R1 reset");
        idle(1);

        // ---- wide variant, clear-on-one ----
        cfg0(0, 8'hEC);                                     // rising, target 4
        expect_at(0, 0, 8'h00, 1'b0, 8'h01, "R11 R12 route");
        p0[0] = 1'b1; expect_at(0, 3, 8'h01, 1'b1, 8'h01, "R2 rising"); idle(4);
        clr0(8'h00);  expect_at(0, 0, 8'h01, 1'b1, 8'h01, "R8 zero write keeps"); idle(1);
        p0[0] = 1'b0; expect_at(0, 3, 8'h01, 1'b1, 8'h01, "R2 sticky on fall"); idle(4);
        clr0(8'h01);  expect_at(0, 0, 8'h00, 1'b0, 8'h01, "R8 one write clears"); idle(1);

        cfg0(1, 8'hF0);                                     // falling
        p0[1] = 1'b1; expect_at(0, 3, 8'h00, 1'b0, 8'h01, "R3 rise ignored"); idle(4);
        p0[1] = 1'b0; expect_at(0, 3, 8'h02, 1'b1, 8'h01, "R3 falling"); idle(4);
        clr0(8'h02); idle(1);

        cfg0(2, 8'hF8);                                     // both edges
        p0[2] = 1'b1; expect_at(0, 3, 8'h04, 1'b1, 8'h01, "R4 both rise"); idle(4);
        clr0(8'h04); idle(1);
        p0[2] = 1'b0; expect_at(0, 3, 8'h04, 1'b1, 8'h01, "R4 both fall"); idle(4);
        clr0(8'h04); idle(1);

        cfg0(3, 8'hE0);                                     // level high
        p0[3] = 1'b1; expect_at(0, 3, 8'h08, 1'b1, 8'h01, "R5 level high"); idle(4);
        clr0(8'h08);  expect_at(0, 0, 8'h08, 1'b1, 8'h01, "R5 held level survives clear"); idle(1);
        p0[3] = 1'b0; expect_at(0, 3, 8'h00, 1'b0, 8'h01, "R5 level released"); idle(4);
        cfg0(3, 8'hC0);                                     // level low
        expect_at(0, 1, 8'h08, 1'b1, 8'h01, "R5 level low"); idle(2);
        p0[3] = 1'b1; expect_at(0, 3, 8'h00, 1'b0, 8'h01, "R5 low released"); idle(4);
        cfg0(3, 8'h00); idle(2);

        cfg0(4, 8'hA8);                                     // rising, gate off
        p0[4] = 1'b1; expect_at(0, 3, 8'h00, 1'b0, 8'h01, "R7 gate off"); idle(4);
        p0[4] = 1'b0; idle(4);

        cfg0(5, 8'h68);                                     // rising, irq disabled
        p0[5] = 1'b1; expect_at(0, 3, 8'h20, 1'b0, 8'h01, "R10 masked pin"); idle(4);
        clr0(8'h20);  expect_at(0, 0, 8'h00, 1'b0, 8'h01, "R10 cleared"); idle(1);

        // same-cycle clear and new edge on pin 0 (rising mode, input 0)
        p0[0] = 1'b1; idle(2);
        clrd0 = 8'h01; clw0 = 1'b1;
        @(negedge clk);
        clw0 = 1'b0; clrd0 = '0;
        expect_at(0, 0, 8'h01, 1'b1, 8'h01, "R9 set beats clear"); idle(1);
        clr0(8'h01); idle(1);

        cfg0(6, 8'h04);
        expect_at(0, 0, 8'h00, 1'b0, 8'h41, "R12 R11 second route"); idle(1);

        // ---- narrow variant, clear-on-zero ----
        cfg1(0, 8'hE8);                                     // edge, polarity 1
        p1[0] = 1'b1; expect_at(1, 3, 8'h01, 1'b1, 8'h00, "R6 narrow rising"); idle(4);
        clr1(4'hF);   expect_at(1, 0, 8'h01, 1'b1, 8'h00, "R8 ones keep (clear-on-zero)"); idle(1);
        clr1(4'hE);   expect_at(1, 0, 8'h00, 1'b0, 8'h00, "R8 zero clears"); idle(1);
        p1[0] = 1'b0; expect_at(1, 3, 8'h00, 1'b0, 8'h00, "R6 opposite edge missed"); idle(4);
        p1[0] = 1'b1; expect_at(1, 3, 8'h01, 1'b1, 8'h00, "R6 rising again"); idle(4);
        cfg1(0, 8'hD8);                                     // polarity flipped, bit4 set
        clr1(4'hE); idle(1);
        p1[0] = 1'b0; expect_at(1, 3, 8'h01, 1'b1, 8'h00, "R6 flipped catches fall"); idle(4);
        clr1(4'hE);   expect_at(1, 0, 8'h00, 1'b0, 8'h00, "R6 cleared"); idle(1);

        while (exq.size() > 0) @(negedge clk);
        idle(2);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule